// File: doc/BRIEF.md
# Translation Unit Control and Interrupt Register Block

This block is the software-facing register file of an address translation unit. It stores the base address of the first-level translation table and reports the unit's state through a status word. A command register takes small opcodes that switch address translation on and off, hold new traffic so that maintenance work can be done safely, flush the translation cache, acknowledge a fault, or reset the whole register set to zero.

On the hardware side, the page walker reports translation faults together with the faulting address and whether the access was a read or a write. It also reports bus read errors. The block records the first fault and keeps it until software acknowledges it. It keeps raw and mask interrupt bits and drives a single level interrupt line. Writing a page address to the single-line flush register produces a one-cycle request to drop that page from the translation cache.

All registers are 32 bits wide and use a byte offset. Writes are single-cycle strobes. Read data is combinational from the offset.

Top module: `xlat_ctl_regs`

## Requirements
- R1: After reset, paging, stall, fault-active, the interrupt line and both flush strobes are low. The table base, mask, raw interrupt, fault address and clock-gating registers read zero. The status word (offset 0x04) reads bit31 set, with only bits 3 and 4 following the idle and replay-empty inputs.
- R2: The table base register (offset 0x00) keeps only bits 31:12 of a write, and bits 11:0 read as zero. For example, a write of 0xCAFEBABE reads back 0xCAFEB000.
- R3: Command opcode 0, written to offset 0x08 in bits 2:0, sets paging-enabled: status bit0 and `paging_on` go high. Opcode 1 clears paging-enabled and also drops stall.
- R4: Opcode 2 sets stall (status bit2, `stall_on`) only while paging is enabled, and is ignored otherwise. Opcode 3 clears stall. Status bit31 always reads as the inverse of bit2.
- R5: A fault event while no fault is active sets fault-active (status bit1) and raw interrupt bit0 (offset 0x14). It captures the address into offset 0x0C and the direction (1 = write) into status bit5.
- R6: While fault-active is set, a new fault event is ignored: the captured address and direction stay as they are. Opcode 5 clears fault-active, and the next fault is then captured.
- R7: A bus error pulse sets raw bit1. The masked status (offset 0x20) reads raw AND the mask (offset 0x1C, bits 1:0). `irq` is high exactly when a masked bit is set.
- R8: Writing 1s to the clear register (offset 0x18) clears those raw bits. A bit set by an event in the same cycle as the clear stays set.
- R9: A write to offset 0x10 drives `zap_one` high for exactly one cycle, starting at the clock edge that accepts the write. During that cycle `zap_addr` carries the written value with bits 11:0 cleared.
- R10: Opcode 4 drives `zap_all` high for exactly one cycle, starting at the clock edge that accepts the write.
- R11: Opcode 6 clears the table base, mask, raw interrupt, fault address, clock-gating register, paging, stall and fault-active.
- R12: Status bit3 mirrors `idle_in` and bit4 mirrors `replay_empty_in`. Offsets outside the map (for example 0x30) read zero. The clock-gating register at 0x24 stores bit0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_we | input | 1 | Register write strobe |
| req_addr | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for `req_addr` |
| flt_evt | input | 1 | Translation fault event pulse |
| flt_addr | input | 32 | Address of the faulting access |
| flt_is_wr | input | 1 | Faulting access was a write |
| bus_err | input | 1 | Bus read error pulse |
| idle_in | input | 1 | Translation unit is idle |
| replay_empty_in | input | 1 | Replay buffer is empty |
| paging_on | output | 1 | Translation enabled |
| stall_on | output | 1 | Traffic held |
| zap_all | output | 1 | Flush-all request, one cycle |
| zap_one | output | 1 | Flush-one-page request, one cycle |
| zap_addr | output | 32 | Page address for `zap_one` |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The hardest cases are the collisions. One is a second fault arriving while the first is still unacknowledged. The other is a clear write landing in the same cycle as a new bus error. The bench raises the first fault, then issues a second fault with a different address and direction, and reads back both the captured address and status bit5. It drives the clear write and the bus error pulse on the same clock edge, then reads the raw register to confirm the bit survived. The stall gating is reached by issuing the stall opcode first with paging off and then again with paging on.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;

    localparam int OFS_W = 8;

    localparam logic [OFS_W-1:0] OFS_BASE   = 8'h00;
    localparam logic [OFS_W-1:0] OFS_STAT   = 8'h04;
    localparam logic [OFS_W-1:0] OFS_CMD    = 8'h08;
    localparam logic [OFS_W-1:0] OFS_FADDR  = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_ZAP1   = 8'h10;
    localparam logic [OFS_W-1:0] OFS_RAW    = 8'h14;
    localparam logic [OFS_W-1:0] OFS_CLR    = 8'h18;
    localparam logic [OFS_W-1:0] OFS_MASK   = 8'h1C;
    localparam logic [OFS_W-1:0] OFS_MSTAT  = 8'h20;
    localparam logic [OFS_W-1:0] OFS_GATE   = 8'h24;

    typedef enum logic [2:0] {
        OP_PG_ON    = 3'd0,
        OP_PG_OFF   = 3'd1,
        OP_STL_ON   = 3'd2,
        OP_STL_OFF  = 3'd3,
        OP_ZAP_ALL  = 3'd4,
        OP_FLT_DONE = 3'd5,
        OP_FRESET   = 3'd6
    } op_e;

    localparam int ST_PAGING = 0;
    localparam int ST_FAULT  = 1;
    localparam int ST_STALL  = 2;
    localparam int ST_IDLE   = 3;
    localparam int ST_REPLAY = 4;
    localparam int ST_FWRITE = 5;

    localparam int IRQ_FAULT  = 0;
    localparam int IRQ_BUSERR = 1;
    localparam int IRQ_N      = 2;

endpackage

// File: rtl/xlat_mode_fsm.sv
module xlat_mode_fsm
    import xlat_ctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  logic [2:0]        cmd_op,
    input  logic              flt_evt,
    input  logic [DATA_W-1:0] flt_addr,
    input  logic              flt_is_wr,
    output logic              paging,
    output logic              stall,
    output logic              flt_act,
    output logic              flt_wr,
    output logic [DATA_W-1:0] flt_addr_q,
    output logic              flt_capt,
    output logic              zap_all
);

    typedef struct packed {
        logic              paging;
        logic              stall;
        logic              flt_act;
        logic              flt_wr;
        logic [DATA_W-1:0] flt_addr;
        logic              zap_all;
    } mode_t;

    mode_t st_d, st_q;
    logic  take_w;
    logic  wipe_w;

    always_comb begin
        st_d         = st_q;
        st_d.zap_all = 1'b0;
        take_w       = flt_evt && !st_q.flt_act;
        wipe_w       = cmd_vld && (cmd_op == OP_FRESET);

        if (take_w) begin
            st_d.flt_act  = 1'b1;
            st_d.flt_addr = flt_addr;
            st_d.flt_wr   = flt_is_wr;
        end

        if (cmd_vld) begin
            case (op_e'(cmd_op))
                OP_PG_ON:    st_d.paging = 1'b1;
                OP_PG_OFF: begin
                    st_d.paging = 1'b0;
                    st_d.stall  = 1'b0;
                end
                OP_STL_ON:   if (st_q.paging) st_d.stall = 1'b1;
                OP_STL_OFF:  st_d.stall = 1'b0;
                OP_ZAP_ALL:  st_d.zap_all = 1'b1;
                OP_FLT_DONE: st_d.flt_act = 1'b0;
                OP_FRESET: begin
                    st_d.paging   = 1'b0;
                    st_d.stall    = 1'b0;
                    st_d.flt_act  = 1'b0;
                    st_d.flt_wr   = 1'b0;
                    st_d.flt_addr = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign paging     = st_q.paging;
    assign stall      = st_q.stall;
    assign flt_act    = st_q.flt_act;
    assign flt_wr     = st_q.flt_wr;
    assign flt_addr_q = st_q.flt_addr;
    assign zap_all    = st_q.zap_all;
    assign flt_capt   = take_w && !wipe_w;

endmodule

// File: rtl/xlat_irq_unit.sv
module xlat_irq_unit #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic            clr_vld,
    input  logic [NSRC-1:0] clr_vec,
    input  logic            mask_wr,
    input  logic [NSRC-1:0] mask_val,
    input  logic            wipe,
    output logic [NSRC-1:0] raw,
    output logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] masked,
    output logic            irq
);

    typedef struct packed {
        logic [NSRC-1:0] raw;
        logic [NSRC-1:0] mask;
    } irq_t;

    irq_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        if (clr_vld) ir_d.raw = ir_q.raw & ~clr_vec;
        ir_d.raw = ir_d.raw | set_vec;
        if (mask_wr) ir_d.mask = mask_val;
        if (wipe) ir_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    assign raw    = ir_q.raw;
    assign mask   = ir_q.mask;
    assign masked = ir_q.raw & ir_q.mask;
    assign irq    = |masked;

endmodule

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs
    import xlat_ctl_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_we,
    input  logic [7:0]        req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              flt_evt,
    input  logic [DATA_W-1:0] flt_addr,
    input  logic              flt_is_wr,
    input  logic              bus_err,
    input  logic              idle_in,
    input  logic              replay_empty_in,
    output logic              paging_on,
    output logic              stall_on,
    output logic              zap_all,
    output logic              zap_one,
    output logic [DATA_W-1:0] zap_addr,
    output logic              irq
);

    localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1));
    localparam int PAD_W = DATA_W - IRQ_N;

    typedef struct packed {
        logic [DATA_W-1:0] base;
        logic              gate;
        logic              zap_one;
        logic [DATA_W-1:0] zap_addr;
    } top_t;

    top_t tp_d, tp_q;

    logic              cmd_vld_w;
    logic              wipe_w;
    logic              fault_act_w;
    logic              fault_wr_w;
    logic [DATA_W-1:0] fault_addr_w;
    logic              flt_capt_w;
    logic [IRQ_N-1:0]  set_w;
    logic [IRQ_N-1:0]  raw_w;
    logic [IRQ_N-1:0]  mask_w;
    logic [IRQ_N-1:0]  masked_w;
    logic [DATA_W-1:0] status_w;

    assign cmd_vld_w = req_we && (req_addr == OFS_CMD);
    assign wipe_w    = cmd_vld_w && (req_wdata[2:0] == OP_FRESET);

    xlat_mode_fsm #(.DATA_W(DATA_W)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_vld    (cmd_vld_w),
        .cmd_op     (req_wdata[2:0]),
        .flt_evt    (flt_evt),
        .flt_addr   (flt_addr),
        .flt_is_wr  (flt_is_wr),
        .paging     (paging_on),
        .stall      (stall_on),
        .flt_act    (fault_act_w),
        .flt_wr     (fault_wr_w),
        .flt_addr_q (fault_addr_w),
        .flt_capt   (flt_capt_w),
        .zap_all    (zap_all)
    );

    always_comb begin
        set_w             = '0;
        set_w[IRQ_FAULT]  = flt_capt_w;
        set_w[IRQ_BUSERR] = bus_err && !wipe_w;
    end

    xlat_irq_unit #(.NSRC(IRQ_N)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_w),
        .clr_vld  (req_we && (req_addr == OFS_CLR)),
        .clr_vec  (req_wdata[IRQ_N-1:0]),
        .mask_wr  (req_we && (req_addr == OFS_MASK)),
        .mask_val (req_wdata[IRQ_N-1:0]),
        .wipe     (wipe_w),
        .raw      (raw_w),
        .mask     (mask_w),
        .masked   (masked_w),
        .irq      (irq)
    );

    always_comb begin
        tp_d         = tp_q;
        tp_d.zap_one = 1'b0;
        if (req_we) begin
            if (req_addr == OFS_BASE) tp_d.base = req_wdata & PAGE_MASK;
            if (req_addr == OFS_GATE) tp_d.gate = req_wdata[0];
            if (req_addr == OFS_ZAP1) begin
                tp_d.zap_one  = 1'b1;
                tp_d.zap_addr = req_wdata & PAGE_MASK;
            end
        end
        if (wipe_w) begin
            tp_d.base = '0;
            tp_d.gate = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    assign zap_one  = tp_q.zap_one;
    assign zap_addr = tp_q.zap_addr;

    always_comb begin
        status_w             = '0;
        status_w[ST_PAGING]  = paging_on;
        status_w[ST_FAULT]   = fault_act_w;
        status_w[ST_STALL]   = stall_on;
        status_w[ST_IDLE]    = idle_in;
        status_w[ST_REPLAY]  = replay_empty_in;
        status_w[ST_FWRITE]  = fault_wr_w;
        status_w[DATA_W-1]   = !stall_on;
    end

    always_comb begin
        case (req_addr)
            OFS_BASE:  rsp_rdata = tp_q.base;
            OFS_STAT:  rsp_rdata = status_w;
            OFS_FADDR: rsp_rdata = fault_addr_w;
            OFS_RAW:   rsp_rdata = {{PAD_W{1'b0}}, raw_w};
            OFS_MASK:  rsp_rdata = {{PAD_W{1'b0}}, mask_w};
            OFS_MSTAT: rsp_rdata = {{PAD_W{1'b0}}, masked_w};
            OFS_GATE:  rsp_rdata = {{(DATA_W-1){1'b0}}, tp_q.gate};
            default:   rsp_rdata = '0;
        endcase
    end

endmodule

// File: rtl/xlat_ctl_chk.sv
module xlat_ctl_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_we,
    input logic [7:0]        req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              paging_on,
    input logic              stall_on,
    input logic              zap_all,
    input logic              zap_one,
    input logic              irq,
    input logic              fault_act,
    input logic [DATA_W-1:0] fault_addr,
    input logic [1:0]        mask
);

    logic cmd_w;
    assign cmd_w = req_we && (req_addr == 8'h08);

    AST_STALL_NEEDS_PAGING: assert property (@(posedge clk) disable iff (!rst_n)
        stall_on |-> paging_on); // R4

    AST_STALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && req_wdata[2:0] == 3'd2 && !paging_on) |=> !stall_on); // R4

    AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_act && !cmd_w) |=> $stable(fault_addr)); // R6

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != 2'b00)); // R7

    AST_ZAP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        zap_one |=> !zap_one || $past(req_we && req_addr == 8'h10)); // R9

    AST_ZAP_ALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && req_wdata[2:0] == 3'd4) |=> zap_all); // R10

    AST_FORCE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && req_wdata[2:0] == 3'd6) |=> (!paging_on && !stall_on && !irq && !fault_act)); // R11

endmodule

bind xlat_ctl_regs xlat_ctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .paging_on  (paging_on),
    .stall_on   (stall_on),
    .zap_all    (zap_all),
    .zap_one    (zap_one),
    .irq        (irq),
    .fault_act  (fault_act_w),
    .fault_addr (fault_addr_w),
    .mask       (mask_w)
);

// File: tb/test_xlat_ctl_regs.sv
module test_xlat_ctl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_we = 1'b0;
    logic [7:0]  req_addr = 8'h00;
    logic [31:0] req_wdata = 32'h0;
    logic [31:0] rsp_rdata;
    logic        flt_evt = 1'b0;
    logic [31:0] flt_addr = 32'h0;
    logic        flt_is_wr = 1'b0;
    logic        bus_err = 1'b0;
    logic        idle_in = 1'b1;
    logic        replay_empty_in = 1'b0;
    logic        paging_on, stall_on, zap_all, zap_one, irq;
    logic [31:0] zap_addr;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    xlat_ctl_regs i_xlat_ctl_regs (
        .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .flt_evt(flt_evt),
        .flt_addr(flt_addr), .flt_is_wr(flt_is_wr), .bus_err(bus_err),
        .idle_in(idle_in), .replay_empty_in(replay_empty_in),
        .paging_on(paging_on), .stall_on(stall_on), .zap_all(zap_all),
        .zap_one(zap_one), .zap_addr(zap_addr), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  wa;
        logic [31:0] wd;
        logic [7:0]  ra;
        logic [31:0] ex;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 32'hCAFEBABE, 8'h00, 32'hCAFEB000},  // R2
        '{8'h08, 32'h00000002, 8'h04, 32'h80000008},  // R4 stall ignored, paging off
        '{8'h08, 32'h00000000, 8'h04, 32'h80000009},  // R3
        '{8'h08, 32'h00000002, 8'h04, 32'h0000000D},  // R4
        '{8'h08, 32'h00000003, 8'h04, 32'h80000009},  // R4
        '{8'h1C, 32'hFFFFFFFF, 8'h1C, 32'h00000003},  // R7
        '{8'h24, 32'h00000003, 8'h24, 32'h00000001},  // R12
        '{8'h08, 32'h00000001, 8'h04, 32'h80000008}   // R3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_we = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        req_addr = a;
        #1;
        d = rsp_rdata;
    endtask

    task automatic fault(input logic [31:0] a, input logic w);
        @(negedge clk);
        flt_evt = 1'b1; flt_addr = a; flt_is_wr = w;
        @(negedge clk);
        flt_evt = 1'b0;
    endtask

    task automatic berr();
        @(negedge clk);
        bus_err = 1'b1;
        @(negedge clk);
        bus_err = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h04, v); chk("R1 status", v, 32'h80000008);
        rd(8'h00, v); chk("R1 base", v, 32'h0);
        rd(8'h0C, v); chk("R1 fault addr", v, 32'h0);
        chk("R1 outputs", {27'h0, paging_on, stall_on, zap_all, zap_one, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].wa, VECS[i].wd);
            rd(VECS[i].ra, v);
            chk($sformatf("vector %0d (R2 R3 R4 R7 R12)", i), v, VECS[i].ex);
        end

        // R5 first fault captured
        fault(32'h12345678, 1'b1);
        rd(8'h04, v); chk("R5 status", v, 32'h8000002A);
        rd(8'h0C, v); chk("R5 fault addr", v, 32'h12345678);
        rd(8'h14, v); chk("R5 raw", v, 32'h1);
        rd(8'h20, v); chk("R7 masked", v, 32'h1);
        chk("R7 irq", {31'h0, irq}, 32'h1);

        // R6 second fault ignored
        fault(32'hDEAD0000, 1'b0);
        rd(8'h0C, v); chk("R6 addr held", v, 32'h12345678);
        rd(8'h04, v); chk("R6 dir held", v, 32'h8000002A);

        // R8 clear
        wr(8'h18, 32'h1);
        rd(8'h14, v); chk("R8 raw cleared", v, 32'h0);
        chk("R8 irq low", {31'h0, irq}, 32'h0);

        // R7 bus error and mask
        berr();
        rd(8'h14, v); chk("R7 raw buserr", v, 32'h2);
        rd(8'h20, v); chk("R7 masked buserr", v, 32'h2);
        chk("R7 irq buserr", {31'h0, irq}, 32'h1);
        wr(8'h1C, 32'h1);
        rd(8'h20, v); chk("R7 masked off", v, 32'h0);
        chk("R7 irq masked", {31'h0, irq}, 32'h0);

        // R8 set wins over same-cycle clear
        @(negedge clk);
        req_we = 1'b1; req_addr = 8'h18; req_wdata = 32'h2; bus_err = 1'b1;
        @(negedge clk);
        req_we = 1'b0; bus_err = 1'b0;
        rd(8'h14, v); chk("R8 set beats clear", v, 32'h2);
        wr(8'h18, 32'h2);
        rd(8'h14, v); chk("R8 raw empty", v, 32'h0);

        // R6 fault done then new capture
        wr(8'h08, 32'h5);
        rd(8'h04, v); chk("R6 done", v, 32'h80000028);
        fault(32'hDEAD0123, 1'b0);
        rd(8'h0C, v); chk("R6 recapture addr", v, 32'hDEAD0123);
        rd(8'h04, v); chk("R6 recapture status", v, 32'h8000000A);

        // R12 mirrors and unmapped
        idle_in = 1'b0; replay_empty_in = 1'b1;
        rd(8'h04, v); chk("R12 mirror", v, 32'h80000012);
        rd(8'h30, v); chk("R12 unmapped", v, 32'h0);

        // R9 zap one
        wr(8'h10, 32'hABCDE777);
        chk("R9 pulse", {31'h0, zap_one}, 32'h1);
        chk("R9 addr", zap_addr, 32'hABCDE000);
        @(negedge clk);
        chk("R9 pulse end", {31'h0, zap_one}, 32'h0);

        // R10 zap all
        chk("R10 idle", {31'h0, zap_all}, 32'h0);
        wr(8'h08, 32'h4);
        chk("R10 pulse", {31'h0, zap_all}, 32'h1);
        @(negedge clk);
        chk("R10 pulse end", {31'h0, zap_all}, 32'h0);

        // R11 force reset
        wr(8'h08, 32'h0);
        wr(8'h08, 32'h2);
        chk("R11 pre", {30'h0, paging_on, stall_on}, 32'h3);
        chk("R11 pre irq", {31'h0, irq}, 32'h1);
        wr(8'h08, 32'h6);
        rd(8'h00, v); chk("R11 base", v, 32'h0);
        rd(8'h1C, v); chk("R11 mask", v, 32'h0);
        rd(8'h14, v); chk("R11 raw", v, 32'h0);
        rd(8'h0C, v); chk("R11 fault addr", v, 32'h0);
        rd(8'h24, v); chk("R11 gate", v, 32'h0);
        rd(8'h04, v); chk("R11 status", v, 32'h80000010);
        chk("R11 outputs", {29'h0, paging_on, stall_on, irq}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule